// File: doc/BRIEF.md
# Privilege-Level Ownership Arbiter

This block decides which of five privilege levels (0 to 4) owns a shared device at any moment. Each level writes to its own control register to ask for access, give it up, take it by force, or re-arm the establishment flag. Each level reads its own status register to learn whether it holds the device and whether a higher level has taken the device from it. One shared state register reports the owner, whether any owner exists, and the establishment flag. An external hash-end pulse clears that flag.

Writes arrive as a single-cycle strobe tagged with the writing level, a register offset and a 4-bit control value. Reads are combinational and are selected by a level and an offset. The owner is also driven directly on two output ports. Command handling and the data path belong to other blocks.

Top module: `priv_owner_arb`

## Requirements
- R1: After synchronous reset no level owns the device, no request is pending, every seized flag is 0 and the establishment flag is 1. The state register reads 0x81.
- R2: The state register occupies byte 0 of the 32-bit read value. Bit 7 is always 1. Bits 4:2 hold the owner level in binary and read 0 when nothing is owned. Bit 1 is 1 while some level owns the device. Bit 0 is the establishment flag. Bits 6:5 and 31:8 are 0.
- R3: A control write at offset 0x08 with bit 0 set (request) marks that level pending. If no level owned the device at the start of that cycle, ownership goes to the highest-numbered pending level at that clock edge, counting the request just written.
- R4: A request made while another level owns the device stays pending. It is granted on the edge after the edge that frees the device.
- R5: A control write with bit 1 set (relinquish) from the owning level frees the device at that edge. The same write from any other level changes nothing.
- R6: A control write with bit 2 set (seize) from a level numbered higher than the current owner makes the writer the owner at that edge and sets the old owner's seized flag. A seize from a level that is equal or lower, or a seize while the device is free, has no effect.
- R7: A level's seized flag clears when that level writes a request (bit 0).
- R8: A control write with bit 3 set sets the establishment flag only when it comes from level 3 or level 4. From levels 0 to 2 it has no effect.
- R9: A hash-end pulse clears the establishment flag at the next edge. It takes precedence over a set in the same cycle.
- R10: Reads at offset 0x00 return the state register. Reads at offset 0x0C return the selected level's status, with bit 0 = granted and bit 1 = seized. The control offset and all other offsets read 0. A write tagged with a level number above 4 is ignored.
- R11: own_valid and own_lvl always agree with the state register, and at most one level reports granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_lvl | input | 3 | Privilege level issuing the write |
| wr_addr | input | 8 | Register offset within the level's window |
| wr_bits | input | 4 | Control value written (bit 0 request, 1 relinquish, 2 seize, 3 re-arm establishment) |
| hash_end | input | 1 | Pulse that clears the establishment flag |
| rd_lvl | input | 3 | Level whose window is read |
| rd_addr | input | 8 | Offset of the register read |
| rd_data | output | 32 | Combinational read value |
| own_valid | output | 1 | Some level owns the device |
| own_lvl | output | 3 | Owning level, 0 when none |

## Verification
The bench targets five corner cases:
- A relinquish written by a non-owner. A design that does not check the writer would free the device from under its owner.
- Seizes that are not strictly upward, and a seize while the device is free. A design that gets these wrong would hand over ownership and leave a stale seized flag.
- Several levels pending when the device frees. The highest level must win, one edge after the release; a lower-first or same-edge grant is caught.
- A re-arm of the establishment flag from levels below 3, and a re-arm that lands in the same cycle as hash-end. A design that gets these wrong would leave the flag wrongly set.
- Writes tagged with a level above 4. A design that truncates the level would let them act as level 0 to 3.

// File: rtl/poa_pkg.sv
package poa_pkg;

    localparam int LVL_W  = 3;
    localparam int ADDR_W = 8;
    localparam int CTL_W  = 4;
    localparam int RD_W   = 32;

    // register offsets inside one level's window
    localparam logic [ADDR_W-1:0] OFS_STATE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h0C;

    // control value bit positions
    localparam int CB_REQ   = 0;
    localparam int CB_REL   = 1;
    localparam int CB_SEIZE = 2;
    localparam int CB_EST   = 3;

    // decoded action of one control write
    typedef struct packed {
        logic             req;
        logic             rel;
        logic             seize;
        logic             set_est;
        logic [LVL_W-1:0] lvl;
    } ctl_act_t;

    function automatic logic [7:0] state_byte(logic v, logic [LVL_W-1:0] l, logic est);
        return {1'b1, 2'b00, (v ? l : {LVL_W{1'b0}}), v, est};
    endfunction

endpackage

// File: rtl/poa_wr_decode.sv
module poa_wr_decode
    import poa_pkg::*;
#(
    parameter int NUM_LVL     = 5,
    parameter int EST_MIN_LVL = 3
) (
    input  logic              wr_en,
    input  logic [LVL_W-1:0]  wr_lvl,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTL_W-1:0]  wr_bits,
    output ctl_act_t          act
);
    logic hit;
    logic est_ok;

    assign hit    = wr_en && (wr_addr == OFS_CTRL) && (int'(wr_lvl) < NUM_LVL);
    assign est_ok = int'(wr_lvl) >= EST_MIN_LVL;

    always_comb begin
        act.req     = hit && wr_bits[CB_REQ];
        act.rel     = hit && wr_bits[CB_REL];
        act.seize   = hit && wr_bits[CB_SEIZE];
        act.set_est = hit && wr_bits[CB_EST] && est_ok;
        act.lvl     = wr_lvl;
    end
endmodule

// File: rtl/poa_owner_core.sv
module poa_owner_core
    import poa_pkg::*;
#(
    parameter int NUM_LVL = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  ctl_act_t           act,
    input  logic               hash_end,
    output logic               own_v,
    output logic [LVL_W-1:0]   own_l,
    output logic               estab,
    output logic [NUM_LVL-1:0] seized,
    output logic [NUM_LVL-1:0] grant
);
    logic               own_v_q, own_v_n;
    logic [LVL_W-1:0]   own_l_q, own_l_n;
    logic               est_q, est_n;
    logic [NUM_LVL-1:0] pend_q, pend_n;
    logic [NUM_LVL-1:0] sz_q, sz_n;
    logic [LVL_W-1:0]   hi;

    always_comb begin
        own_v_n = own_v_q;
        own_l_n = own_l_q;
        est_n   = est_q;
        pend_n  = pend_q;
        sz_n    = sz_q;
        hi      = '0;

        if (act.req) begin
            if (!(own_v_q && own_l_q == act.lvl)) pend_n[act.lvl] = 1'b1;
            sz_n[act.lvl] = 1'b0;
        end
        if (act.rel && own_v_q && own_l_q == act.lvl) begin
            own_v_n = 1'b0;
            own_l_n = '0;
        end
        if (act.seize && own_v_q && act.lvl > own_l_q) begin
            sz_n[own_l_q]   = 1'b1;
            own_l_n         = act.lvl;
            pend_n[act.lvl] = 1'b0;
        end
        if (act.set_est) est_n = 1'b1;
        if (hash_end)    est_n = 1'b0;

        // arbitration only when the device was free at the start of the cycle
        for (int i = 0; i < NUM_LVL; i++)
            if (pend_n[i]) hi = LVL_W'(i);
        if (!own_v_q && |pend_n) begin
            own_v_n    = 1'b1;
            own_l_n    = hi;
            pend_n[hi] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_v_q <= 1'b0;
            own_l_q <= '0;
            est_q   <= 1'b1;
            pend_q  <= '0;
            sz_q    <= '0;
        end else begin
            own_v_q <= own_v_n;
            own_l_q <= own_l_n;
            est_q   <= est_n;
            pend_q  <= pend_n;
            sz_q    <= sz_n;
        end
    end

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_grant
        assign grant[g] = own_v_q && (own_l_q == LVL_W'(g));
    end

    assign own_v  = own_v_q;
    assign own_l  = own_l_q;
    assign estab  = est_q;
    assign seized = sz_q;
endmodule

// File: rtl/poa_read_mux.sv
module poa_read_mux
    import poa_pkg::*;
#(
    parameter int NUM_LVL = 5
) (
    input  logic [LVL_W-1:0]   rd_lvl,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               own_v,
    input  logic [LVL_W-1:0]   own_l,
    input  logic               estab,
    input  logic [NUM_LVL-1:0] seized,
    input  logic [NUM_LVL-1:0] grant,
    output logic [RD_W-1:0]    rd_data
);
    logic [1:0] stat_w [NUM_LVL];
    logic [1:0] stat_sel;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_stat
        assign stat_w[g] = {seized[g], grant[g]};
    end

    always_comb begin
        stat_sel = 2'b00;
        for (int i = 0; i < NUM_LVL; i++)
            if (int'(rd_lvl) == i) stat_sel = stat_w[i];
    end

    always_comb begin
        case (rd_addr)
            OFS_STATE: rd_data = {{(RD_W-8){1'b0}}, state_byte(own_v, own_l, estab)};
            OFS_STAT:  rd_data = {{(RD_W-2){1'b0}}, stat_sel};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/priv_owner_arb.sv
module priv_owner_arb
    import poa_pkg::*;
#(
    parameter int NUM_LVL     = 5,
    parameter int EST_MIN_LVL = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LVL_W-1:0]  wr_lvl,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CTL_W-1:0]  wr_bits,
    input  logic              hash_end,
    input  logic [LVL_W-1:0]  rd_lvl,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RD_W-1:0]   rd_data,
    output logic              own_valid,
    output logic [LVL_W-1:0]  own_lvl
);
    ctl_act_t           act_w;
    logic               estab_w;
    logic [NUM_LVL-1:0] seized_w;
    logic [NUM_LVL-1:0] grant_w;

    poa_wr_decode #(.NUM_LVL(NUM_LVL), .EST_MIN_LVL(EST_MIN_LVL)) u_dec (
        .wr_en   (wr_en),
        .wr_lvl  (wr_lvl),
        .wr_addr (wr_addr),
        .wr_bits (wr_bits),
        .act     (act_w)
    );

    poa_owner_core #(.NUM_LVL(NUM_LVL)) u_core (
        .clk      (clk),
        .rst      (rst),
        .act      (act_w),
        .hash_end (hash_end),
        .own_v    (own_valid),
        .own_l    (own_lvl),
        .estab    (estab_w),
        .seized   (seized_w),
        .grant    (grant_w)
    );

    poa_read_mux #(.NUM_LVL(NUM_LVL)) u_rd (
        .rd_lvl  (rd_lvl),
        .rd_addr (rd_addr),
        .own_v   (own_valid),
        .own_l   (own_lvl),
        .estab   (estab_w),
        .seized  (seized_w),
        .grant   (grant_w),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/poa_checker.sv
module poa_checker
    import poa_pkg::*;
#(
    parameter int NUM_LVL     = 5,
    parameter int EST_MIN_LVL = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [LVL_W-1:0]   wr_lvl,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [CTL_W-1:0]   wr_bits,
    input logic               hash_end,
    input logic               own_valid,
    input logic [LVL_W-1:0]   own_lvl,
    input logic               estab,
    input logic [NUM_LVL-1:0] grant
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == OFS_CTRL) && (int'(wr_lvl) < NUM_LVL);

    AST_FREE_REQ_GRANT: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && wr_bits[CB_REQ] && !own_valid |=> own_valid); // R3

    AST_SEIZE_UPWARD: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && wr_bits[CB_SEIZE] && own_valid && (wr_lvl > own_lvl)
        |=> own_valid && (own_lvl == $past(wr_lvl))); // R6

    AST_FOREIGN_RELQ: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && wr_bits[CB_REL] && !wr_bits[CB_SEIZE] && own_valid && (wr_lvl != own_lvl)
        |=> own_valid && (own_lvl == $past(own_lvl))); // R5

    AST_LOW_EST_HOLD: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && wr_bits[CB_EST] && (int'(wr_lvl) < EST_MIN_LVL) && !hash_end
        |=> $stable(estab)); // R8

    AST_HASH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        hash_end |=> !estab); // R9

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (own_valid == (|grant))); // R11
endmodule

bind priv_owner_arb poa_checker #(.NUM_LVL(NUM_LVL), .EST_MIN_LVL(EST_MIN_LVL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_lvl    (wr_lvl),
    .wr_addr   (wr_addr),
    .wr_bits   (wr_bits),
    .hash_end  (hash_end),
    .own_valid (own_valid),
    .own_lvl   (own_lvl),
    .estab     (estab_w),
    .grant     (grant_w)
);

// File: tb/priv_owner_arb_bench.sv
module priv_owner_arb_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_lvl = '0;
    logic [7:0]  wr_addr = '0;
    logic [3:0]  wr_bits = '0;
    logic        hash_end = 1'b0;
    logic [2:0]  rd_lvl = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        own_valid;
    logic [2:0]  own_lvl;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_owner_arb u_priv_owner_arb (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_lvl(wr_lvl), .wr_addr(wr_addr),
        .wr_bits(wr_bits), .hash_end(hash_end), .rd_lvl(rd_lvl), .rd_addr(rd_addr),
        .rd_data(rd_data), .own_valid(own_valid), .own_lvl(own_lvl)
    );

    // behavioural reference
    int m_ov, m_ol, m_est;
    int m_pend [NL];
    int m_sz [NL];

    always @(posedge clk) begin : ref_model
        int L, hi;
        if (rst) begin
            m_ov = 0; m_ol = 0; m_est = 1;
            for (int i = 0; i < NL; i++) begin m_pend[i] = 0; m_sz[i] = 0; end
        end else begin
            int was_owned;
            was_owned = m_ov;
            L = int'(wr_lvl);
            if (wr_en && wr_addr == 8'h08 && L < NL) begin
                if (wr_bits[0]) begin
                    if (!(m_ov == 1 && m_ol == L)) m_pend[L] = 1;
                    m_sz[L] = 0;
                end
                if (wr_bits[1] && m_ov == 1 && m_ol == L) begin m_ov = 0; m_ol = 0; end
                else if (wr_bits[2] && was_owned == 1 && L > m_ol) begin
                    m_sz[m_ol] = 1; m_ol = L; m_pend[L] = 0;
                end
                if (wr_bits[3] && L >= 3) m_est = 1;
            end
            if (hash_end) m_est = 0;
            if (was_owned == 0) begin
                hi = -1;
                for (int i = 0; i < NL; i++) if (m_pend[i] != 0) hi = i;
                if (hi >= 0) begin m_ov = 1; m_ol = hi; m_pend[hi] = 0; end
            end
        end
    end

    function automatic logic [31:0] exp_rd();
        int l;
        l = int'(rd_lvl);
        if (rd_addr == 8'h00)
            return 32'(128 + (m_ov ? m_ol * 4 : 0) + m_ov * 2 + m_est);
        if (rd_addr == 8'h0C && l < NL)
            return 32'(m_sz[l] * 2 + ((m_ov == 1 && m_ol == l) ? 1 : 0));
        return 32'd0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        chk("R11 owner ports vs model", {own_valid, own_lvl}, (m_ov << 3) | m_ol);
        chk("R10 read value vs model", int'(rd_data), int'(exp_rd()));
    endtask

    task automatic wr(int l, int d);
        wr_en = 1'b1; wr_lvl = 3'(l); wr_addr = 8'h08; wr_bits = 4'(d);
        tick();
        wr_en = 1'b0; wr_bits = '0;
    endtask

    task automatic setrd(int l, int a);
        rd_lvl = 3'(l); rd_addr = 8'(a);
        tick();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 reset state read", int'(rd_data), 'h81);
        chk("R1 reset no owner", int'(own_valid), 0);

        wr(1, 1);
        chk("R3 free grant level", int'(own_lvl), 1);
        chk("R2 state encoding", int'(rd_data), 'h87);
        wr(0, 1);
        chk("R4 pending while owned", int'(own_lvl), 1);
        wr(2, 2);
        chk("R5 foreign relinquish ignored", {own_valid, own_lvl}, 'h9);
        wr(1, 2);
        chk("R5 owner relinquish frees", int'(own_valid), 0);
        tick();
        chk("R4 pending granted after free", {own_valid, own_lvl}, 'h8);
        chk("R2 state for level 0 owner", int'(rd_data), 'h83);

        wr(1, 1); wr(2, 1); wr(0, 2);
        tick();
        chk("R3 highest pending wins", int'(own_lvl), 2);

        wr(4, 4);
        chk("R6 upward seize", int'(own_lvl), 4);
        setrd(2, 'h0C);
        chk("R6 seized flag set", int'(rd_data), 2);
        wr(3, 4); wr(2, 4);
        chk("R6 lower seize ignored", int'(own_lvl), 4);
        wr(2, 1);
        chk("R7 request clears seized", int'(rd_data), 0);
        setrd(4, 'h0C);
        chk("R10 owner status granted", int'(rd_data), 1);
        setrd(0, 'h08);
        chk("R10 control offset reads zero", int'(rd_data), 0);
        setrd(0, 'h00);
        chk("R2 state level 4", int'(rd_data), 'h93);

        hash_end = 1'b1; tick(); hash_end = 1'b0;
        chk("R9 hash end clears", int'(rd_data), 'h92);
        wr(2, 8);
        chk("R8 low level rearm ignored", int'(rd_data), 'h92);
        wr(3, 8);
        chk("R8 level 3 rearm", int'(rd_data), 'h93);
        hash_end = 1'b1; wr(4, 8); hash_end = 1'b0;
        chk("R9 hash beats rearm", int'(rd_data), 'h92);

        wr(5, 2); wr(7, 6);
        chk("R10 out-of-range level ignored", {own_valid, own_lvl}, 'hC);

        wr(4, 2);
        chk("R5 free after release", int'(own_valid), 0);
        tick();
        chk("R3 grant 2 of pending 1,2", int'(own_lvl), 2);
        wr(2, 2); tick();
        chk("R4 next pending", int'(own_lvl), 1);
        wr(1, 2); tick();
        chk("R5 nothing pending stays free", int'(own_valid), 0);
        wr(3, 4);
        chk("R6 seize while free ignored", int'(own_valid), 0);
        wr(3, 1);
        chk("R3 immediate grant", {own_valid, own_lvl}, 'hB);

        for (int n = 0; n < 600; n++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            wr_en    = ($urandom_range(0, 3) != 0);
            wr_lvl   = 3'($urandom_range(0, 7));
            wr_addr  = (sel < 7) ? 8'h08 : (sel == 7 ? 8'h0C : 8'($urandom));
            wr_bits  = 4'($urandom);
            hash_end = ($urandom_range(0, 15) == 0);
            rd_lvl   = 3'($urandom_range(0, 7));
            rd_addr  = ($urandom_range(0, 1) != 0) ? 8'h00 : 8'h0C;
            tick();
        end
        wr_en = 1'b0; hash_end = 1'b0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule